// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block sits between an asynchronous host bus and the byte-wide register file of a small timekeeping peripheral. Two host pins carry the bus protocol, and a static strap input chooses what they mean. With the strap high, one pin is a data strobe and the other gives the transfer direction. With the strap low, the same two pins act as separate active-low read and write strobes. Each convention has its own edge rules for starting a cycle and capturing data.

The pins go through a two-flop synchronizer into the system clock, and edges are found on the synchronized copies. Chip select gates every access. A bank-select level, sampled when a cycle starts, sends the access either to the core register space or to an extra 128-byte storage bank. The address is latched when the cycle starts. Write data is taken when the write strobe completes.

Reads produce a one-cycle read-enable pulse for the selected space and an output-drive enable for the data bus. Writes leave through a valid/ready port. The payload is held stable while `wr_ready` is low. A write that completes while an earlier one is still waiting is discarded, so the port never queues more than one transfer.

Top module: `rtcbus_if`

## Requirements
- R1: With `mode_hi`=1, a rising edge on `ds_pin` while `rw_pin`=1 starts a read. It gives one single-cycle read-enable pulse, and `bus_oe` stays high until `ds_pin` falls. The address is taken at the rising edge.
- R2: With `mode_hi`=1, a rising edge on `ds_pin` while `rw_pin`=0 starts a write and latches the address. The falling edge of `ds_pin` captures `wdata_in` and presents one write on the output port.
- R3: With `mode_hi`=0, a falling edge on `ds_pin` (active-low read strobe) starts a read. It gives one read-enable pulse, and `bus_oe` stays high until `ds_pin` returns high. The address is taken at the falling edge.
- R4: With `mode_hi`=0, a falling edge on `rw_pin` (active-low write strobe) latches the address. The following rising edge captures `wdata_in` and presents one write.
- R5: A strobe edge that arrives while `cs_n`=1 starts nothing. No read-enable pulse, no `bus_oe` and no write result from it.
- R6: `bank_sel`=1 at cycle start routes the access to the extra bank: the read pulse appears on `rd_bank`, or the write carries `wr_bank`=1. `bank_sel`=0 routes it to `rd_core`, or to `wr_bank`=0. The two read pulses are never high together.
- R7: While `rst_n`=0, all outputs are 0 and every strobe is ignored. After reset, `acc_addr` reads 0.
- R8: While `wr_valid`=1 and `wr_ready`=0, `wr_valid`, `wr_addr`, `wr_data` and `wr_bank` hold. A write that completes during that time is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; blocks all accesses |
| mode_hi | input | 1 | Strap: 1 = strobe plus direction, 0 = separate read/write strobes |
| cs_n | input | 1 | Active-low chip select |
| ds_pin | input | 1 | Data strobe (mode 1) or active-low read strobe (mode 0) |
| rw_pin | input | 1 | Direction, 1 = read (mode 1) or active-low write strobe (mode 0) |
| bank_sel | input | 1 | 1 selects the extra 128-byte bank |
| addr_in | input | ADDR_W | Host address |
| wdata_in | input | DATA_W | Host write data |
| bus_oe | output | 1 | Data bus drive enable, high during a read |
| acc_addr | output | ADDR_W | Address latched at the start of the current or last cycle |
| rd_core | output | 1 | One-cycle read enable, core space |
| rd_bank | output | 1 | One-cycle read enable, extra bank |
| wr_valid | output | 1 | Write transfer valid |
| wr_ready | input | 1 | Register file accepts the write |
| wr_bank | output | 1 | Write targets the extra bank |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |

## Verification
A wrong cycle state shows at the ports within about three clocks of the strobe edge. It appears as a missing or doubled read pulse, a `bus_oe` that does not drop when the strobe ends, or a write where none was due. A wrong edge polarity for one mode shows as an address sampled at the wrong moment, or as data that belongs to the value on the bus before the write strobe ended. The bench changes both buses in the middle of each cycle so that either fault produces a visibly different value. A broken hold stage shows as a second write overwriting a stalled one before `wr_ready` rises.

// File: rtl/rtcbus_pkg.sv
package rtcbus_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/rtcbus_sync.sv
module rtcbus_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rtcbus_edge.sv
module rtcbus_edge #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/rtcbus_decode.sv
module rtcbus_decode
  import rtcbus_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_hi,
  input  logic              rw_lvl,
  input  logic              cs_n_lvl,
  input  logic              ds_rise,
  input  logic              ds_fall,
  input  logic              rw_rise,
  input  logic              rw_fall,
  input  logic              bank_raw,
  input  logic [ADDR_W-1:0] addr_raw,
  input  logic [DATA_W-1:0] data_raw,
  output logic              bus_oe,
  output logic              rd_core,
  output logic              rd_bank,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              cap_valid,
  output logic              cap_bank,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data
);
  cyc_e              state_q, state_d;
  logic              bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic              start_rd, start_wr, end_rd, end_wr, commit_wr;

  // Edge meaning depends on the strap
  always_comb begin
    if (mode_hi) begin
      start_rd = ds_rise & rw_lvl & ~cs_n_lvl;
      start_wr = ds_rise & ~rw_lvl & ~cs_n_lvl;
      end_rd   = ds_fall | cs_n_lvl;
      end_wr   = ds_fall;
    end else begin
      start_rd = ds_fall & ~cs_n_lvl;
      start_wr = rw_fall & ~cs_n_lvl & ~ds_fall;
      end_rd   = ds_rise | cs_n_lvl;
      end_wr   = rw_rise;
    end
    commit_wr = (state_q == CYC_WRITE) & end_wr & ~cs_n_lvl;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CYC_IDLE: begin
        if (start_rd)      state_d = CYC_READ;
        else if (start_wr) state_d = CYC_WRITE;
      end
      CYC_READ:  if (end_rd) state_d = CYC_IDLE;
      CYC_WRITE: if (end_wr || cs_n_lvl) state_d = CYC_IDLE;
      default:   state_d = CYC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= CYC_IDLE;
      bank_q    <= 1'b0;
      addr_q    <= '0;
      rd_core   <= 1'b0;
      rd_bank   <= 1'b0;
      cap_valid <= 1'b0;
      cap_bank  <= 1'b0;
      cap_addr  <= '0;
      cap_data  <= '0;
    end else begin
      state_q   <= state_d;
      rd_core   <= 1'b0;
      rd_bank   <= 1'b0;
      cap_valid <= 1'b0;
      if (state_q == CYC_IDLE && (start_rd || start_wr)) begin
        addr_q <= addr_raw;
        bank_q <= bank_raw;
        if (start_rd) begin
          rd_core <= ~bank_raw;
          rd_bank <= bank_raw;
        end
      end
      if (commit_wr) begin
        cap_valid <= 1'b1;
        cap_bank  <= bank_q;
        cap_addr  <= addr_q;
        cap_data  <= data_raw;
      end
    end
  end

  assign bus_oe   = (state_q == CYC_READ);
  assign acc_addr = addr_q;

  p_rd_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_core || rd_bank) |=> !(rd_core || rd_bank));
  p_oe_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> (rd_core || rd_bank));
  p_cs_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_lvl |=> !$rose(bus_oe) && !rd_core && !rd_bank);
  p_rd_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_core, rd_bank}));
endmodule

// File: rtl/rtcbus_wrhold.sv
module rtcbus_wrhold #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_valid,
  input  logic              cap_bank,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              wr_bank,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic stalled;
  assign stalled = wr_valid & ~wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_bank  <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (!stalled) begin
      wr_valid <= cap_valid;
      if (cap_valid) begin
        wr_bank <= cap_bank;
        wr_addr <= cap_addr;
        wr_data <= cap_data;
      end
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_data)
                               && $stable(wr_addr) && $stable(wr_bank));
endmodule

// File: rtl/rtcbus_if.sv
module rtcbus_if
  import rtcbus_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_hi,
  input  logic              cs_n,
  input  logic              ds_pin,
  input  logic              rw_pin,
  input  logic              bank_sel,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic              bus_oe,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              rd_core,
  output logic              rd_bank,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              wr_bank,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int NPIN = 3;

  logic [NPIN-1:0]   pins_s;
  logic [1:0]        rise, fall;
  logic              cap_valid, cap_bank;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;

  rtcbus_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL({NPIN{1'b1}})) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, rw_pin, ds_pin}), .q(pins_s)
  );

  rtcbus_edge #(.W(2), .RST_VAL(2'b11)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pins_s[1:0]), .rise(rise), .fall(fall)
  );

  rtcbus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .mode_hi(mode_hi),
    .rw_lvl(pins_s[1]), .cs_n_lvl(pins_s[2]),
    .ds_rise(rise[0]), .ds_fall(fall[0]), .rw_rise(rise[1]), .rw_fall(fall[1]),
    .bank_raw(bank_sel), .addr_raw(addr_in), .data_raw(wdata_in),
    .bus_oe(bus_oe), .rd_core(rd_core), .rd_bank(rd_bank), .acc_addr(acc_addr),
    .cap_valid(cap_valid), .cap_bank(cap_bank), .cap_addr(cap_addr), .cap_data(cap_data)
  );

  rtcbus_wrhold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .cap_valid(cap_valid), .cap_bank(cap_bank), .cap_addr(cap_addr), .cap_data(cap_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_bank(wr_bank),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  p_no_wr_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_core || rd_bank) |-> !cap_valid);
endmodule

// File: tb/rtcbus_if_tb.sv
module rtcbus_if_tb;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_hi = 1'b1, cs_n = 1'b1, ds_pin = 1'b0, rw_pin = 1'b1, bank_sel = 1'b0;
  logic [6:0] addr_in = '0;
  logic [7:0] wdata_in = '0;
  logic       wr_ready = 1'b1;
  logic       bus_oe, rd_core, rd_bank, wr_valid, wr_bank;
  logic [6:0] acc_addr, wr_addr;
  logic [7:0] wr_data;

  always #(CLK_NS/2) clk = ~clk;

  rtcbus_if u_dut (
    .clk(clk), .rst_n(rst_n), .mode_hi(mode_hi), .cs_n(cs_n), .ds_pin(ds_pin),
    .rw_pin(rw_pin), .bank_sel(bank_sel), .addr_in(addr_in), .wdata_in(wdata_in),
    .bus_oe(bus_oe), .acc_addr(acc_addr), .rd_core(rd_core), .rd_bank(rd_bank),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_bank(wr_bank),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int n_checks = 0, n_errors = 0;
  int n_rc = 0, n_rb = 0, n_w = 0;
  logic       l_bank;
  logic [6:0] l_addr;
  logic [7:0] l_data;

  always @(negedge clk) begin
    if (rd_core) n_rc++;
    if (rd_bank) n_rb++;
    if (wr_valid && wr_ready) begin
      n_w++; l_bank = wr_bank; l_addr = wr_addr; l_data = wr_data;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic m; logic w; logic c; logic bk;
    logic [6:0] a; logic [7:0] d;
    logic erc; logic erb; logic ew;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 7'h05, 8'h00, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 7'h12, 8'hA5, 1'b0, 1'b0, 1'b1},
    '{1'b1, 1'b0, 1'b0, 1'b1, 7'h7F, 8'h00, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b1, 7'h00, 8'h3C, 1'b0, 1'b0, 1'b1},
    '{1'b0, 1'b0, 1'b0, 1'b0, 7'h21, 8'h00, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 7'h44, 8'h81, 1'b0, 1'b0, 1'b1},
    '{1'b0, 1'b0, 1'b0, 1'b1, 7'h33, 8'h00, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b1, 7'h7E, 8'hFF, 1'b0, 1'b0, 1'b1},
    '{1'b1, 1'b1, 1'b1, 1'b0, 7'h09, 8'h55, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b1, 1'b1, 7'h0A, 8'h00, 1'b0, 1'b0, 1'b0}
  };

  function automatic string req_of(input vec_t v);
    if (v.c) return "R5";
    if (v.m) return v.w ? "R2" : "R1";
    return v.w ? "R4" : "R3";
  endfunction

  // One host cycle; address and data are swapped mid-cycle to expose sampling points
  task automatic bus_cycle(input logic m, w, c, bk, input logic [6:0] a, input logic [7:0] d,
                           output logic oe_mid, output logic [6:0] am);
    mode_hi = m;
    repeat (2) @(negedge clk);
    cs_n = c; bank_sel = bk; addr_in = a; wdata_in = d ^ 8'hFF;
    if (m) begin ds_pin = 1'b0; rw_pin = ~w; end
    else   begin ds_pin = 1'b1; rw_pin = 1'b1; end
    repeat (4) @(negedge clk);
    if (m) ds_pin = 1'b1;
    else if (w) rw_pin = 1'b0;
    else ds_pin = 1'b0;
    repeat (5) @(negedge clk);
    oe_mid = bus_oe; am = acc_addr;
    addr_in = ~a; wdata_in = d;
    repeat (2) @(negedge clk);
    if (m) ds_pin = 1'b0;
    else begin ds_pin = 1'b1; rw_pin = 1'b1; end
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_checks++; n_errors++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic oe_m; logic [6:0] am;
    int rc0, rb0, w0;
    repeat (3) @(negedge clk);
    chk("R7", "bus_oe in reset", int'(bus_oe), 0);
    chk("R7", "wr_valid in reset", int'(wr_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7", "acc_addr after reset", int'(acc_addr), 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      string r = req_of(v);
      rc0 = n_rc; rb0 = n_rb; w0 = n_w;
      bus_cycle(v.m, v.w, v.c, v.bk, v.a, v.d, oe_m, am);
      chk(r, "rd_core pulses", n_rc - rc0, int'(v.erc));
      chk(r, "rd_bank pulses", n_rb - rb0, int'(v.erb));
      chk(r, "writes", n_w - w0, int'(v.ew));
      chk(r, "bus_oe mid-cycle", int'(oe_m), int'(!v.w && !v.c));
      chk(r, "bus_oe after cycle", int'(bus_oe), 0);
      if (!v.c) chk(r, "address sampled at start", int'(am), int'(v.a));
      if (v.ew) begin
        chk(r, "wr_addr", int'(l_addr), int'(v.a));
        chk(r, "wr_data taken at strobe end", int'(l_data), int'(v.d));
        chk("R6", "wr_bank", int'(l_bank), int'(v.bk));
      end
    end

    // R8: stalled write holds, second write is dropped
    wr_ready = 1'b0;
    w0 = n_w;
    bus_cycle(1'b1, 1'b1, 1'b0, 1'b1, 7'h2B, 8'h6D, oe_m, am);
    chk("R8", "wr_valid while stalled", int'(wr_valid), 1);
    chk("R8", "wr_data while stalled", int'(wr_data), 8'h6D);
    bus_cycle(1'b0, 1'b1, 1'b0, 1'b0, 7'h11, 8'h99, oe_m, am);
    chk("R8", "wr_data after second write", int'(wr_data), 8'h6D);
    chk("R8", "wr_addr after second write", int'(wr_addr), 7'h2B);
    wr_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", "writes accepted", n_w - w0, 1);
    chk("R8", "accepted data", int'(l_data), 8'h6D);
    chk("R8", "wr_valid after accept", int'(wr_valid), 0);

    // R7: cycles during reset do nothing
    rst_n = 1'b0;
    rc0 = n_rc; w0 = n_w;
    bus_cycle(1'b1, 1'b1, 1'b0, 1'b0, 7'h3E, 8'h42, oe_m, am);
    bus_cycle(1'b0, 1'b0, 1'b0, 1'b0, 7'h3F, 8'h00, oe_m, am);
    chk("R7", "reads in reset", n_rc - rc0, 0);
    chk("R7", "writes in reset", n_w - w0, 0);
    chk("R7", "bus_oe in reset read", int'(oe_m), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // recovery after reset
    rc0 = n_rc;
    bus_cycle(1'b1, 1'b0, 1'b0, 1'b0, 7'h66, 8'h00, oe_m, am);
    chk("R1", "read after reset", n_rc - rc0, 1);
    chk("R1", "bus_oe after reset read", int'(oe_m), 1);

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule